// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block judges a single conditional branch in one combinational step. It takes a 16-bit instruction word, the four condition flags (negative, zero, overflow, carry) and the program counter that already points past the branch word. From these it reports whether the word belongs to the branch group and whether the branch is taken. It also gives the program counter to use next: the branch target when taken, and the incoming value otherwise.

The condition is chosen by instruction bit 15 together with bits 10:8, which form a 4-bit code. Each code owns a 16-bit truth mask, and the 4-bit flag value picks one bit of that mask. A decoder upstream is expected to pass only words from the branch class. The block itself looks at no other bits to decide validity.

Top module: `branch_eval`

## Requirements
- R1: The condition code is {instr[15], instr[10:8]}. `branch_valid` is 1 for every code except 0000 (the operate group). Bits 14:11 and 7:0 never change `branch_valid`.
- R2: Code 0001 (word 0000400 octal) is taken for every flag value.
- R3: The flag index is {N,Z,V,C} = flags[3:0], with N at bit 3 and C at bit 0. Codes 0010 NE (taken when !Z), 0011 EQ (Z), 1000 PL (!N), 1001 MI (N), 1100 VC (!V), 1101 VS (V), 1110 CC (!C) and 1111 CS (C) each test a single flag.
- R4: The signed codes are 0100 GE (N==V), 0101 LT (N!=V), 0110 GT (!(Z or N!=V)) and 0111 LE (Z or N!=V).
- R5: The unsigned codes are 1010 HI (taken when neither C nor Z is set) and 1011 LOS (C or Z).
- R6: When taken, `next_pc` = `pc_in` + 2 × sign-extended instr[7:0], wrapping modulo 2^PC_W. The reach is −256 to +254 bytes.
- R7: When a valid branch is not taken, `next_pc` equals `pc_in`.
- R8: When `branch_valid` is 0, `taken` is 0 and `next_pc` equals `pc_in` for any flags and any offset.
- R9: All outputs are pure functions of the present inputs, with no state and no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word under evaluation |
| flags | input | 4 | Condition flags {N,Z,V,C} |
| pc_in | input | PC_W | Program counter already advanced past the branch word |
| branch_valid | output | 1 | Word lies in the conditional branch group |
| taken | output | 1 | Branch condition holds |
| next_pc | output | PC_W | Target when taken, else `pc_in` |

## Verification
Every result of this block is due in the same cycle as its stimulus, with zero registers on the path. The bench therefore applies each input vector on the falling clock edge and samples all three outputs one nanosecond later, well before the next rising edge. The expected taken value comes from a flag expression per condition, written independently of the mask tables. The expected target comes from signed arithmetic in the bench.

// File: rtl/branch_eval.sv
module branch_eval #(
  parameter int PC_W = 16
) (
  input  logic [15:0]     instr,
  input  logic [3:0]      flags,
  input  logic [PC_W-1:0] pc_in,
  output logic            branch_valid,
  output logic            taken,
  output logic [PC_W-1:0] next_pc
);
  localparam int OFS_W = 8;
  localparam int EXT_W = PC_W - OFS_W - 1;

  logic [3:0]      code;
  logic [15:0]     mask;
  logic [PC_W-1:0] disp;
  logic            unused_bits;

  assign code        = {instr[15], instr[10:8]};
  assign unused_bits = ^instr[14:11];

  always_comb begin
    unique case (code)
      4'h0: mask = 16'h0000;
      4'h1: mask = 16'hFFFF;
      4'h2: mask = 16'h0F0F;
      4'h3: mask = 16'hF0F0;
      4'h4: mask = 16'hCC33;
      4'h5: mask = 16'h33CC;
      4'h6: mask = 16'h0C03;
      4'h7: mask = 16'hF3FC;
      4'h8: mask = 16'h00FF;
      4'h9: mask = 16'hFF00;
      4'hA: mask = 16'h0505;
      4'hB: mask = 16'hFAFA;
      4'hC: mask = 16'h3333;
      4'hD: mask = 16'hCCCC;
      4'hE: mask = 16'h5555;
      default: mask = 16'hAAAA;
    endcase
  end

  assign branch_valid = (code != 4'h0);
  assign taken        = mask[flags];
  assign disp         = {{EXT_W{instr[7]}}, instr[7:0], 1'b0};
  assign next_pc      = taken ? pc_in + disp : pc_in;

  logic [PC_W-1:0] pc_delta;
  assign pc_delta = next_pc - pc_in;

  always_comb begin
    if (!$isunknown({instr, flags, pc_in})) begin
      // R8
      invalid_not_taken_chk: assert (branch_valid || !taken);
      // R7
      hold_pc_chk: assert (taken || next_pc == pc_in);
      // R2
      always_taken_chk: assert (!(instr[15] == 1'b0 && instr[10:8] == 3'b001) || taken);
      // R6
      branch_span_chk: assert (pc_delta[0] == 1'b0 &&
                               pc_delta[PC_W-1:OFS_W] == {(PC_W-OFS_W){pc_delta[OFS_W]}});
    end
  end
endmodule

// File: tb/tb_branch_eval.sv
module tb_branch_eval;
  localparam int PC_W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0]     instr;
  logic [3:0]      flags;
  logic [PC_W-1:0] pc_in;
  logic            branch_valid, taken;
  logic [PC_W-1:0] next_pc;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  branch_eval #(.PC_W(PC_W)) dut (
    .instr(instr), .flags(flags), .pc_in(pc_in),
    .branch_valid(branch_valid), .taken(taken), .next_pc(next_pc)
  );

  function automatic bit exp_taken(input logic [15:0] w, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case ({w[15], w[10:8]})
      4'h1: return 1'b1;
      4'h2: return !z;
      4'h3: return z;
      4'h4: return n == v;
      4'h5: return n != v;
      4'h6: return !(z || (n != v));
      4'h7: return z || (n != v);
      4'h8: return !n;
      4'h9: return n;
      4'hA: return !(c || z);
      4'hB: return c || z;
      4'hC: return !v;
      4'hD: return v;
      4'hE: return !c;
      4'hF: return c;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [PC_W-1:0] exp_pc(input logic [15:0] w, input logic [3:0] f,
                                              input logic [PC_W-1:0] p);
    int off;
    off = int'($signed(w[7:0])) * 2;
    if (exp_taken(w, f)) return p + PC_W'(off);
    return p;
  endfunction

  function automatic string tag_of(input logic [15:0] w);
    case ({w[15], w[10:8]})
      4'h0: return "R8";
      4'h1: return "R2";
      4'h4, 4'h5, 4'h6, 4'h7: return "R4";
      4'hA, 4'hB: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic apply(input logic [15:0] w, input logic [3:0] f, input logic [PC_W-1:0] p);
    @(negedge clk);
    instr = w; flags = f; pc_in = p;
    #1;
  endtask

  task automatic check_all(input string tag);
    bit ev, et;
    logic [PC_W-1:0] ep;
    ev = ({instr[15], instr[10:8]} != 4'h0);
    et = exp_taken(instr, flags);
    ep = exp_pc(instr, flags, pc_in);
    checks++;
    if (branch_valid !== ev) begin
      errors++;
      $display("FAIL R1 valid instr=%o act=%b exp=%b", instr, branch_valid, ev);
    end
    checks++;
    if (taken !== et) begin
      errors++;
      $display("FAIL %s taken instr=%o flags=%b act=%b exp=%b", tag, instr, flags, taken, et);
    end
    checks++;
    if (next_pc !== ep) begin
      errors++;
      $display("FAIL %s next_pc instr=%o pc=%h act=%h exp=%h", tag, instr, pc_in, next_pc, ep);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R9: initial vector, combinational outputs at once
    apply(16'o000000, 4'b0000, 16'h1000); check_all("R9");
    // R8: operate group, all flags, large offset
    for (int f = 0; f < 16; f++) begin
      apply(16'o000377, 4'(f), 16'h2000); check_all("R8");
    end
    // R1: bits 14:11 set with code 0 stay invalid; with code set stay valid
    apply(16'o074000, 4'hF, 16'h0100); check_all("R1");
    apply(16'o074400, 4'h0, 16'h0100); check_all("R1");
    // R2: always taken for all flags
    for (int f = 0; f < 16; f++) begin
      apply(16'o000405, 4'(f), 16'h0400); check_all("R2");
    end
    // R3 R4 R5 exhaustive code x flag sweep
    for (int cd = 1; cd < 16; cd++) begin
      for (int f = 0; f < 16; f++) begin
        logic [15:0] w;
        w = {cd[3], 4'b0000, cd[2:0], 8'h10};
        apply(w, 4'(f), 16'h3000); check_all(tag_of(w));
      end
    end
    // R6: extreme offsets and wrap
    apply(16'o000600, 4'h0, 16'h1000); check_all("R6");
    apply(16'o000577, 4'h0, 16'h1000); check_all("R6");
    apply(16'o000401, 4'h0, 16'hFFFE); check_all("R6");
    apply(16'o000777, 4'h0, 16'h0000); check_all("R6");
    // R7: EQ not taken with Z clear keeps pc
    apply(16'o001577, 4'b0000, 16'h5554); check_all("R7");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      w = 16'($urandom());
      apply(w, 4'($urandom()), PC_W'($urandom()));
      check_all(tag_of(w));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule